// File: doc/BRIEF.md
# Byte Scan Multiplexer with Cascade Hand-off

This block puts a 32-bit snapshot onto an 8-bit shared bus, one byte per host request. A host pulses a scan strobe; the block drives the current byte while the strobe is high. On each falling edge of the strobe it moves to the next byte. After the most significant byte it parks in a terminal slot. In that slot the bus stays released and a cascade-enable output drops.

The cascade-enable output is wired to the active-low enable of the next device on the same bus. Every device shares the strobe and a combined active-low reload input. When a device finishes, the next one starts, so a string of devices unloads device by device, each from least to most significant byte.

The reload input does two things while it is low. It returns the sequencer to the first byte, and it asserts the snapshot-load output for the counter latches that feed `snap_val`. The strobe, reload and enable inputs are asynchronous to the system clock and are synchronized before use.

Top module: `byte_scan_mux`

## Requirements
- R1: After system reset the sequencer selects byte 0, `casc_en` is 1, `bus_oe` is 0, `bus_data` is 0 and `snap_load` is 0.
- R2: While `rld_n` is low, `snap_load` is 1 and the sequencer returns to byte 0. Once `rld_n` is high again, `snap_load` is 0.
- R3: With `en_n` low, each falling edge of `scan_strb` advances the sequencer by one slot. The slots are byte 0 to byte 3 and then the terminal slot. Byte k is `snap_val[8k+7:8k]`.
- R4: In the terminal slot, further strobe edges leave the sequencer parked. Only a low `rld_n` takes it back to byte 0.
- R5: `bus_oe` is 1 only when the synchronized strobe is high, `en_n` is low and the sequencer is not in the terminal slot. In that case `bus_data` is the selected byte. When `bus_oe` is 0, `bus_data` is 0.
- R6: `casc_en` is 0 exactly while the sequencer is in the terminal slot, and 1 otherwise.
- R7: While `en_n` is high, strobe edges do not advance the sequencer and the bus stays released.
- R8: `en_n` is taken at the falling edge of the strobe. Lowering `en_n` while the strobe is already high causes no advance.
- R9: If a low `rld_n` and a strobe falling edge reach the sequencer in the same clock cycle, the reload wins and the sequencer selects byte 0.
- R10: When two devices share the strobe and `rld_n`, and the first device's `casc_en` drives the second device's `en_n`, the shared bus carries the first device's bytes 0 to 3 and then the second device's bytes 0 to 3. No two devices drive the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| snap_val | input | 32 | Latched value to be presented |
| scan_strb | input | 1 | Host scan strobe, asynchronous |
| rld_n | input | 1 | Active-low reload: restart at byte 0 and load the snapshot |
| en_n | input | 1 | Active-low enable, asynchronous |
| bus_data | output | 8 | Byte currently presented, 0 when released |
| bus_oe | output | 1 | Drive enable for the bus |
| snap_load | output | 1 | Snapshot-load request to the latches |
| casc_en | output | 1 | Enable for the next device, low in the terminal slot |

## Verification
The hardest case to reach from the ports is a reload and a strobe falling edge that arrive in the same clock cycle. The bench gets there by changing both inputs on the same clock edge. Both inputs pass through equal-length synchronizers, so they reach the sequencer together. The reload is held low for exactly one clock, so only correct priority leaves the sequencer on byte 0; a longer reload pulse would hide a wrong priority. The cascade case uses a second instance, with its enable fed from the first instance's `casc_en`, and the bench rebuilds the shared bus from both instances.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int IDX_STRB  = 0;
    localparam int IDX_RLD   = 1;
    localparam int IDX_EN    = 2;
    localparam int NUM_CTRL  = 3;
    // idle levels of the control inputs: strobe low, reload and enable inactive high
    localparam logic [NUM_CTRL-1:0] CTRL_IDLE = 3'b110;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
    parameter int                 N_SIG   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [N_SIG-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] dout
);
    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int NUM_BYTES = 4,
    parameter int STATE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strb_s,
    input  logic               rld_s_n,
    input  logic               en_s_n,
    output logic [STATE_W-1:0] slot,
    output logic               strb_fall
);
    localparam logic [STATE_W-1:0] TERM = STATE_W'(NUM_BYTES);

    typedef struct packed {
        logic [STATE_W-1:0] slot;
        logic               strb_prev;
    } seq_t;

    seq_t seq_d, seq_q;

    assign strb_fall = seq_q.strb_prev & ~strb_s;

    always_comb begin
        seq_d           = seq_q;
        seq_d.strb_prev = strb_s;
        if (!rld_s_n) begin
            // reload wins over a same-cycle falling edge
            seq_d.slot = '0;
        end else if (strb_fall && !en_s_n && seq_q.slot != TERM) begin
            seq_d.slot = seq_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign slot = seq_q.slot;
endmodule

// File: rtl/byte_pick.sv
module byte_pick #(
    parameter int DATA_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int STATE_W   = 3
) (
    input  logic [DATA_W-1:0]  value,
    input  logic [STATE_W-1:0] sel,
    input  logic               drive,
    output logic [BYTE_W-1:0]  data
);
    logic [NUM_BYTES-1:0][BYTE_W-1:0] lanes;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] gated;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        assign lanes[b] = value[b*BYTE_W +: BYTE_W];
        assign gated[b] = (drive && sel == STATE_W'(b)) ? lanes[b] : '0;
    end

    always_comb begin
        data = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            data = data | gated[b];
        end
    end
endmodule

// File: rtl/byte_scan_mux.sv
module byte_scan_mux #(
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] snap_val,
    input  logic              scan_strb,
    input  logic              rld_n,
    input  logic              en_n,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              snap_load,
    output logic              casc_en
);
    import scan_pkg::*;

    localparam int NUM_BYTES = DATA_W / BYTE_W;
    localparam int STATE_W   = $clog2(NUM_BYTES + 1);
    localparam logic [STATE_W-1:0] TERM = STATE_W'(NUM_BYTES);

    logic [NUM_CTRL-1:0] ctrl_raw;
    logic [NUM_CTRL-1:0] ctrl_s;
    logic                strb_s;
    logic                rld_s_n;
    logic                en_s_n;
    logic [STATE_W-1:0]  slot;
    logic                strb_fall;
    logic                live;

    always_comb begin
        ctrl_raw           = '0;
        ctrl_raw[IDX_STRB] = scan_strb;
        ctrl_raw[IDX_RLD]  = rld_n;
        ctrl_raw[IDX_EN]   = en_n;
    end

    scan_sync #(
        .N_SIG   (NUM_CTRL),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTRL_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ctrl_raw),
        .dout  (ctrl_s)
    );

    assign strb_s  = ctrl_s[IDX_STRB];
    assign rld_s_n = ctrl_s[IDX_RLD];
    assign en_s_n  = ctrl_s[IDX_EN];

    scan_seq #(
        .NUM_BYTES (NUM_BYTES),
        .STATE_W   (STATE_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_s    (strb_s),
        .rld_s_n   (rld_s_n),
        .en_s_n    (en_s_n),
        .slot      (slot),
        .strb_fall (strb_fall)
    );

    assign live      = (slot != TERM);
    assign bus_oe    = strb_s & ~en_s_n & live;
    assign casc_en   = live;
    assign snap_load = ~rld_s_n;

    byte_pick #(
        .DATA_W    (DATA_W),
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES),
        .STATE_W   (STATE_W)
    ) pick_i (
        .value (snap_val),
        .sel   (slot),
        .drive (bus_oe),
        .data  (bus_data)
    );
endmodule

// File: rtl/scan_mux_chk.sv
module scan_mux_chk #(
    parameter int STATE_W   = 3,
    parameter int NUM_BYTES = 4,
    parameter int BYTE_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STATE_W-1:0] slot,
    input logic               strb_fall,
    input logic               strb_s,
    input logic               rld_s_n,
    input logic               en_s_n,
    input logic               bus_oe,
    input logic [BYTE_W-1:0]  bus_data,
    input logic               casc_en,
    input logic               snap_load
);
    localparam logic [STATE_W-1:0] TERM = STATE_W'(NUM_BYTES);

    a_r2_reload_first: assert property (@(posedge clk) disable iff (!rst_n)
        !rld_s_n |=> slot == '0);

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_s_n && strb_fall && !en_s_n && slot != TERM) |=> slot == $past(slot) + 1'b1);

    a_r4_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_s_n && slot == TERM) |=> slot == TERM);

    a_r5_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_data == '0);

    a_r5_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (strb_s && !en_s_n && casc_en));

    a_r6_casc_low_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc_en && rld_s_n) |=> !casc_en);

    a_r7_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_s_n && en_s_n) |=> $stable(slot));

    a_r8_no_edge_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_s_n && !strb_fall) |=> $stable(slot));

    a_r2_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rld_s_n) |-> snap_load);
endmodule

bind byte_scan_mux scan_mux_chk #(
    .STATE_W   (STATE_W),
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .strb_fall (strb_fall),
    .strb_s    (strb_s),
    .rld_s_n   (rld_s_n),
    .en_s_n    (en_s_n),
    .bus_oe    (bus_oe),
    .bus_data  (bus_data),
    .casc_en   (casc_en),
    .snap_load (snap_load)
);

// File: tb/byte_scan_mux_tb_top.sv
module byte_scan_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] val_a = 32'hA4B3C2D1;
    logic [31:0] val_b = 32'h5E6F7081;
    logic        scan_strb = 1'b0;
    logic        rld_n = 1'b1;
    logic        en_n = 1'b1;
    logic [7:0]  data_a, data_b;
    logic        oe_a, oe_b, load_a, load_b, casc_a, casc_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    byte_scan_mux dut_i (
        .clk(clk), .rst_n(rst_n), .snap_val(val_a), .scan_strb(scan_strb),
        .rld_n(rld_n), .en_n(en_n), .bus_data(data_a), .bus_oe(oe_a),
        .snap_load(load_a), .casc_en(casc_a)
    );

    byte_scan_mux dut_b_i (
        .clk(clk), .rst_n(rst_n), .snap_val(val_b), .scan_strb(scan_strb),
        .rld_n(rld_n), .en_n(casc_a), .bus_data(data_b), .bus_oe(oe_b),
        .snap_load(load_b), .casc_en(casc_b)
    );

    function automatic logic [7:0] byte_of(logic [31:0] v, int k);
        return v[k*8 +: 8];
    endfunction

    task automatic settle(int n = 6);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic reload();
        rld_n = 1'b0;
        settle();
        chk_eq("R2", "snap_load while reload low", {31'b0, load_a}, 32'h1);
        rld_n = 1'b1;
        settle();
        chk_eq("R2", "snap_load after reload", {31'b0, load_a}, 32'h0);
    endtask

    task automatic strobe_hi();
        scan_strb = 1'b1;
        settle();
    endtask

    task automatic strobe_lo();
        scan_strb = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        chk_eq("R1", "casc_en after reset", {31'b0, casc_a}, 32'h1);
        chk_eq("R1", "bus_oe after reset", {31'b0, oe_a}, 32'h0);
        chk_eq("R1", "bus_data after reset", {24'b0, data_a}, 32'h0);
        chk_eq("R1", "snap_load after reset", {31'b0, load_a}, 32'h0);
        en_n = 1'b0;
        strobe_hi();
        chk_eq("R1", "first byte after reset", {24'b0, data_a}, {24'b0, byte_of(val_a, 0)});
        strobe_lo();
        en_n = 1'b1;
        settle();
    endtask

    task automatic t_full_scan();
        en_n = 1'b0;
        reload();
        for (int k = 0; k < 4; k++) begin
            strobe_hi();
            chk_eq("R3", $sformatf("oe byte %0d", k), {31'b0, oe_a}, 32'h1);
            chk_eq("R3", $sformatf("data byte %0d", k), {24'b0, data_a}, {24'b0, byte_of(val_a, k)});
            chk_eq("R6", "casc_en while scanning", {31'b0, casc_a}, 32'h1);
            strobe_lo();
            chk_eq("R5", "oe with strobe low", {31'b0, oe_a}, 32'h0);
            chk_eq("R5", "data with strobe low", {24'b0, data_a}, 32'h0);
        end
        chk_eq("R6", "casc_en in terminal", {31'b0, casc_a}, 32'h0);
        strobe_hi();
        chk_eq("R5", "oe in terminal", {31'b0, oe_a}, 32'h0);
        chk_eq("R5", "data in terminal", {24'b0, data_a}, 32'h0);
        strobe_lo();
        strobe_hi();
        strobe_lo();
        chk_eq("R4", "still parked", {31'b0, casc_a}, 32'h0);
        reload();
        chk_eq("R4", "reload leaves terminal", {31'b0, casc_a}, 32'h1);
        strobe_hi();
        chk_eq("R4", "byte 0 after reload", {24'b0, data_a}, {24'b0, byte_of(val_a, 0)});
        strobe_lo();
    endtask

    task automatic t_disabled();
        en_n = 1'b0;
        reload();
        en_n = 1'b1;
        settle();
        strobe_hi();
        chk_eq("R7", "oe while disabled", {31'b0, oe_a}, 32'h0);
        strobe_lo();
        strobe_hi();
        strobe_lo();
        en_n = 1'b0;
        settle();
        strobe_hi();
        chk_eq("R7", "no advance while disabled", {24'b0, data_a}, {24'b0, byte_of(val_a, 0)});
        strobe_lo();
    endtask

    task automatic t_enable_mid_strobe();
        en_n = 1'b1;
        settle();
        reload();
        strobe_hi();
        en_n = 1'b0;
        settle();
        chk_eq("R8", "byte 0 after enable mid-strobe", {24'b0, data_a}, {24'b0, byte_of(val_a, 0)});
        strobe_lo();
        strobe_hi();
        chk_eq("R8", "one step after enable", {24'b0, data_a}, {24'b0, byte_of(val_a, 1)});
        strobe_lo();
    endtask

    task automatic t_priority();
        en_n = 1'b0;
        reload();
        strobe_hi();
        strobe_lo();
        strobe_hi();
        chk_eq("R9", "byte 1 before clash", {24'b0, data_a}, {24'b0, byte_of(val_a, 1)});
        // one-clock reload together with the strobe falling edge
        scan_strb = 1'b0;
        rld_n = 1'b0;
        @(negedge clk);
        rld_n = 1'b1;
        settle();
        strobe_hi();
        chk_eq("R9", "reload wins over edge", {24'b0, data_a}, {24'b0, byte_of(val_a, 0)});
        strobe_lo();
    endtask

    task automatic t_cascade();
        logic [7:0] got;
        en_n = 1'b0;
        reload();
        for (int k = 0; k < 8; k++) begin
            strobe_hi();
            chk_eq("R10", "single driver", {30'b0, oe_a, oe_b}, (k < 4) ? 32'h2 : 32'h1);
            got = oe_a ? data_a : (oe_b ? data_b : 8'h00);
            chk_eq("R10", $sformatf("shared bus slot %0d", k), {24'b0, got},
                   {24'b0, (k < 4) ? byte_of(val_a, k) : byte_of(val_b, k - 4)});
            strobe_lo();
        end
        chk_eq("R10", "last device done", {30'b0, casc_a, casc_b}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_full_scan();
        t_disabled();
        t_enable_mid_strobe();
        t_priority();
        t_cascade();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule